// File: doc/BRIEF.md
# Receive FIFO with watermark-driven transfer request

This block buffers words arriving from a serial receiver and tells the rest of the chip when to come and collect them. Incoming words are accepted only while the receive-enable control is high. The buffer is drained either by a processor read strobe or by a single-cycle DMA acknowledge. Each of these removes the oldest word, which is always presented on the read-data port.

Two flags describe the buffer. The full flag reports that no free slot remains. The transfer-request flag reports that the occupancy has risen above a programmable watermark. Every DMA acknowledge drops the request for at least one clock. If the occupancy is still above the watermark, the request then comes back, so an engine that samples the level sees one request per transfer. A sticky overrun bit records words that were lost because the buffer was full. Each of the two flags has its own interrupt enable, and both flags read as inactive while the receiver is disabled.

Top module: `rx_fifo_wm`

## Requirements
- R1: A word is stored when `in_valid` and `rx_en` are both 1 and the buffer holds fewer than DEPTH words. `fill_level` counts the stored words, and words leave in the order they arrived.
- R2: Status bit 0 (full) is 1 exactly when `rx_en` is 1 and `fill_level` equals DEPTH. A read that removes a word from a full buffer brings it back to 0.
- R3: A cycle with `cpu_rd` or `dma_ack` high removes one word, even when both are high. `rd_data` shows the oldest word, or 0 when the buffer is empty. A removal request on an empty buffer changes nothing.
- R4: A word stored and a word removed in the same cycle leave `fill_level` unchanged.
- R5: A word offered while the buffer is full is dropped and sets status bit 2 (overrun). The bit stays set until a cycle with `rx_en` at 0.
- R6: Status bit 1 (request) becomes 1 one clock after a cycle in which `rx_en` is 1, `dma_ack` is 0 and `fill_level` is greater than `wm`.
- R7: The request is 0 one clock after any cycle in which `fill_level` is not greater than `wm`.
- R8: The request is 0 in the cycle after every `dma_ack`. It comes back one clock later if the level is still above `wm`.
- R9: While `rx_en` is 0, `status` is 0, `irq` is 0 and offered words are not stored.
- R10: `irq` is 1 exactly when (full and `full_ie`) or (request and `req_ie`).
- R11: Status bits 7 to 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| in_valid | input | 1 | Received word present |
| in_data | input | 32 | Received word |
| cpu_rd | input | 1 | Processor read strobe, removes the oldest word |
| dma_ack | input | 1 | One-cycle DMA acknowledge, removes the oldest word |
| wm | input | 4 | Request watermark |
| full_ie | input | 1 | Interrupt enable for the full flag |
| req_ie | input | 1 | Interrupt enable for the request flag |
| rd_data | output | 32 | Oldest stored word, or 0 when empty |
| fill_level | output | 5 | Number of stored words |
| status | output | 8 | bit0 full, bit1 request, bit2 overrun, others 0 |
| irq | output | 1 | Combined maskable interrupt |

## Verification
The bench builds the block with its default parameters: 16 words of 32 bits, a 4-bit watermark and a 5-bit level. With these values the full boundary, the overrun path and every watermark from 0 to 15 can be reached in a few dozen cycles. The extreme watermarks matter most. A watermark of 0 raises the request with a single word stored. A watermark of 15 raises it only when the buffer is completely full, which places the request and the full flag on the same entry. A long stretch of mixed pushes, reads, acknowledges and enable changes is compared against a queue model on every clock.

// File: rtl/rx_fifo_wm_pkg.sv
package rx_fifo_wm_pkg;

  typedef struct packed {
    logic [4:0] rsvd;
    logic       ovr;
    logic       req;
    logic       full;
  } rx_stat_t;

  // occupancy after one cycle of push/pop
  function automatic int unsigned fill_next(int unsigned cnt, logic push, logic pop);
    return cnt + (push ? 32'd1 : 32'd0) - (pop ? 32'd1 : 32'd0);
  endfunction

  // request condition: strictly above the watermark
  function automatic logic above_mark(int unsigned cnt, int unsigned mark);
    return cnt > mark;
  endfunction

  // circular pointer advance for any depth
  function automatic int unsigned ptr_wrap(int unsigned p, int unsigned depth);
    return (p + 32'd1 == depth) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_wm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output logic [CW-1:0]     cnt,
  output logic              full_raw,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              drop
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt_q;
  logic              empty;

  assign empty    = (cnt_q == '0);
  assign full_raw = (cnt_q == CW'(DEPTH));
  assign push_ok  = push_req && !full_raw;
  assign drop     = push_req && full_raw;
  assign pop_ok   = pop_req && !empty;
  assign cnt      = cnt_q;
  assign head_data = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ptr_wrap(32'(wr_ptr), 32'(DEPTH)));
      if (pop_ok)  rd_ptr <= AW'(ptr_wrap(32'(rd_ptr), 32'(DEPTH)));
      cnt_q <= CW'(fill_next(32'(cnt_q), push_ok, pop_ok));
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_data;
  end

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_pushpop_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(cnt_q));

  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req) |=> (cnt_q == '0));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full_raw && !pop_req) |=> (cnt_q == CW'(DEPTH)));

endmodule

// File: rtl/rx_fifo_req.sv
module rx_fifo_req
  import rx_fifo_wm_pkg::*;
#(
  parameter int CW   = 5,
  parameter int WM_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic            dma_ack,
  input  logic [CW-1:0]   cnt,
  input  logic [WM_W-1:0] wm,
  output logic            req
);

  logic above;
  logic ack_clear;
  logic req_q;

  assign above     = above_mark(32'(cnt), 32'(wm));
  assign ack_clear = dma_ack || !rx_en;
  assign req       = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_q <= 1'b0;
    else if (ack_clear) req_q <= 1'b0;
    else                req_q <= above;
  end

  assert_req_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !dma_ack && above) |=> req_q);

  assert_req_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !above |=> !req_q);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !req_q);

  assert_req_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !req_q);

endmodule

// File: rtl/rx_fifo_stat.sv
module rx_fifo_stat
  import rx_fifo_wm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       full_raw,
  input  logic       req,
  input  logic       drop,
  input  logic       full_ie,
  input  logic       req_ie,
  output logic [7:0] status,
  output logic       irq
);

  rx_stat_t st;
  logic     ovr_q;
  logic     full_vis, req_vis;

  assign full_vis = rx_en && full_raw;
  assign req_vis  = rx_en && req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (!rx_en) ovr_q <= 1'b0;
    else if (drop)   ovr_q <= 1'b1;
  end

  always_comb begin
    st      = '0;
    st.full = full_vis;
    st.req  = req_vis;
    st.ovr  = rx_en && ovr_q;
  end

  assign status = st;
  assign irq    = (full_vis && full_ie) || (req_vis && req_ie);

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && rx_en) |=> ovr_q);

  assert_quiet_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (status == 8'h00 && !irq));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status[0] && full_ie) || (status[1] && req_ie)));

  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:3] == 5'b0);

endmodule

// File: rtl/rx_fifo_wm.sv
module rx_fifo_wm
  import rx_fifo_wm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int WM_W   = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cpu_rd,
  input  logic              dma_ack,
  input  logic [WM_W-1:0]   wm,
  input  logic              full_ie,
  input  logic              req_ie,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     fill_level,
  output logic [7:0]        status,
  output logic              irq
);

  logic push_req, pop_req;
  logic full_raw, push_ok, pop_ok, drop;
  logic req;

  assign push_req = in_valid && rx_en;
  assign pop_req  = cpu_rd || dma_ack;

  rx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .wr_data   (in_data),
    .pop_req   (pop_req),
    .head_data (rd_data),
    .cnt       (fill_level),
    .full_raw  (full_raw),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .drop      (drop)
  );

  rx_fifo_req #(.CW(CW), .WM_W(WM_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .dma_ack (dma_ack),
    .cnt     (fill_level),
    .wm      (wm),
    .req     (req)
  );

  rx_fifo_stat u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .full_raw (full_raw),
    .req      (req),
    .drop     (drop),
    .full_ie  (full_ie),
    .req_ie   (req_ie),
    .status   (status),
    .irq      (irq)
  );

  assert_push_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !pop_ok) |=> $stable(fill_level));

  assert_single_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && dma_ack && !push_ok && fill_level != '0)
      |=> (fill_level == $past(fill_level) - 1'b1));

endmodule

// File: tb/tb_rx_fifo_wm.sv
`timescale 1ns/1ps
module tb_rx_fifo_wm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0, in_valid = 1'b0, cpu_rd = 1'b0, dma_ack = 1'b0;
  logic [31:0] in_data = '0;
  logic [3:0]  wm = '0;
  logic        full_ie = 1'b0, req_ie = 1'b0;
  logic [31:0] rd_data;
  logic [4:0]  fill_level;
  logic [7:0]  status;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  int unsigned mq[$];
  bit m_req = 1'b0, m_ovr = 1'b0;
  int unsigned seq_no = 1;

  always #2 clk = ~clk;

  rx_fifo_wm dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
    .in_data(in_data), .cpu_rd(cpu_rd), .dma_ack(dma_ack), .wm(wm),
    .full_ie(full_ie), .req_ie(req_ie), .rd_data(rd_data),
    .fill_level(fill_level), .status(status), .irq(irq)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit e_full, e_req, e_ovr, e_irq;
    int unsigned e_head;
    e_full = rx_en && (mq.size() == 16);
    e_req  = rx_en && m_req;
    e_ovr  = rx_en && m_ovr;
    e_irq  = (e_full && full_ie) || (e_req && req_ie);
    e_head = (mq.size() != 0) ? mq[0] : 0;
    check(fill_level == 5'(mq.size()), "R1 level", int'(fill_level), mq.size());
    check(rd_data == e_head, "R3 head", int'(rd_data), int'(e_head));
    check(status[0] == e_full, "R2 full", int'(status[0]), int'(e_full));
    check(status[1] == e_req, "R6 request", int'(status[1]), int'(e_req));
    check(status[2] == e_ovr, "R5 overrun", int'(status[2]), int'(e_ovr));
    check(status[7:3] == 5'b0, "R11 reserved", int'(status[7:3]), 0);
    check(irq == e_irq, "R10 irq", int'(irq), int'(e_irq));
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic step(bit v, bit rd, bit ack);
    bit push, pop, n_req, n_ovr;
    in_valid = v;
    in_data  = seq_no * 32'h9E37_79B1;
    cpu_rd   = rd;
    dma_ack  = ack;
    push  = v && rx_en && (mq.size() < 16);
    pop   = (rd || ack) && (mq.size() > 0);
    n_req = (!rx_en || ack) ? 1'b0 : (mq.size() > int'(wm));
    n_ovr = !rx_en ? 1'b0 : (m_ovr || (v && mq.size() == 16));
    @(posedge clk);
    @(negedge clk);
    if (pop)  void'(mq.pop_front());
    if (push) begin mq.push_back(in_data); seq_no++; end
    m_req = n_req;
    m_ovr = n_ovr;
    compare_all();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    check(status == 8'h00, "R9 reset status", int'(status), 0);

    // fill to full with watermark 5, both interrupts enabled
    rx_en = 1'b1; wm = 4'd5; full_ie = 1'b1; req_ie = 1'b1;
    for (int i = 0; i < 16; i++) step(1, 0, 0);
    check(status[0] == 1'b1, "R2 full at depth", int'(status[0]), 1);
    // overflow attempts
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    check(status[2] == 1'b1, "R5 overrun set", int'(status[2]), 1);
    check(fill_level == 5'd16, "R5 level kept", int'(fill_level), 16);
    // one read clears full
    step(0, 1, 0);
    check(status[0] == 1'b0, "R2 full cleared by read", int'(status[0]), 0);
    check(status[2] == 1'b1, "R5 overrun sticky", int'(status[2]), 1);
    // read and ack together removes one word only
    lvl = fill_level;
    step(0, 1, 1);
    check(fill_level == 5'(lvl - 1), "R3 dual strobe single pop", int'(fill_level), lvl - 1);
    // DMA acks with idle gaps: request must drop after each ack, then re-arm
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1);
      check(status[1] == 1'b0, "R8 ack clears", int'(status[1]), 0);
      step(0, 0, 0);
      step(0, 0, 0);
      check(status[1] == 1'b1, "R8 re-arm", int'(status[1]), 1);
    end
    // drain by reads to the watermark
    while (fill_level > 5) step(0, 1, 0);
    step(0, 0, 0);
    check(status[1] == 1'b0, "R7 clear at mark", int'(status[1]), 0);
    // push and pop together
    lvl = fill_level;
    step(1, 1, 0);
    check(fill_level == 5'(lvl), "R4 push+pop level", int'(fill_level), lvl);
    // drain fully, then reads and acks on empty
    while (fill_level > 0) step(0, 1, 0);
    step(0, 1, 0);
    step(0, 0, 1);
    check(fill_level == 5'd0 && rd_data == 32'd0, "R3 empty read", int'(rd_data), 0);
    // watermark 0: one word raises request
    wm = 4'd0;
    step(1, 0, 0);
    step(0, 0, 0);
    check(status[1] == 1'b1, "R6 wm0 one word", int'(status[1]), 1);
    req_ie = 1'b0;
    step(0, 0, 0);
    check(irq == 1'b0, "R10 masked request", int'(irq), 0);
    // disable: pushes ignored, status quiet
    rx_en = 1'b0;
    step(1, 0, 0);
    check(status == 8'h00 && irq == 1'b0, "R9 disabled quiet", int'(status), 0);
    check(fill_level == 5'd1, "R9 push ignored", int'(fill_level), 1);
    step(1, 0, 0);
    rx_en = 1'b1;
    step(0, 0, 0);
    check(status[2] == 1'b0, "R5 overrun cleared by disable", int'(status[2]), 0);
    // watermark 15: request only at full
    wm = 4'd15;
    while (fill_level < 15) step(1, 0, 0);
    step(0, 0, 0);
    check(status[1] == 1'b0, "R7 wm15 at 15", int'(status[1]), 0);
    step(1, 0, 0);
    step(0, 0, 0);
    check(status[1] == 1'b1 && status[0] == 1'b1, "R6 wm15 at full", int'(status[1:0]), 3);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      if ((i % 97) == 0) wm = 4'(r >> 20);
      if ((i % 53) == 0) begin full_ie = r[24]; req_ie = r[25]; end
      if ((i % 211) == 0) rx_en = (r[27:26] != 2'b00);
      step(r[2:0] < 3'd5, r[5:3] == 3'd0, r[8:6] == 3'd1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule